// File: doc/BRIEF.md
# Spare-Slice Chain Routing Tables

This unit holds the routing state that lets working cores of an eight-tile multiprocessor borrow the L2 slices of tiles whose core has failed. It keeps three tables, each indexed by tile:

- **Search table.** For each working core, a bit vector of the spare slices that core searches for data.
- **Sharer table.** For each spare slice, a bit vector of the cores whose blocks may sit in that slice. Coherence actions use it to pick their targets.
- **Next-hop table.** For each tile, a pointer that says where a block evicted from that tile's cache goes next. The pointers form a chain from a core's own L2 through spare slices and end at main memory.

Software programs all three tables through a single write port. It may do so at boot, before a program starts, or while a program is running. Lookup ports answer in the same cycle. A search lookup returns a core's spare-slice set with the core's own tile bit removed. A sharer lookup returns the sharer set of a slice. An eviction lookup returns either the destination tile or a flag that sends the block to memory.

A chain walker checks a programmed chain. Starting from a source tile, it follows the next-hop pointers one hop per cycle. It reports the number of hops and the last slice reached, and it flags an error when a pointer leads back to a tile it has already visited. A next-hop write that hits a tile on the walk in progress cancels the walk.

Top module: `ec_route_tables`

## Requirements
- R1: After reset:
  - every search and sharer vector is zero;
  - every next-hop entry is invalid, so an eviction lookup reports memory;
  - the walker is idle.
- R2: A write with selector 0 stores `wr_data_i` as the search vector of tile `wr_tile_i`. The new value is visible on the search lookup from the clock edge that takes the write.
- R3: `srch_set_o` equals the search vector of `srch_core_i` with bit `srch_core_i` forced to 0.
- R4: A write with selector 1 stores `wr_data_i` as the sharer vector of tile `wr_tile_i`. `shr_set_o` returns the sharer vector of `shr_slice_i` unmasked.
- R5: A write with selector 2 stores a next-hop entry. `wr_data_i[3]` is the valid bit and `wr_data_i[2:0]` is the destination tile.
  - If the entry for `evict_src_i` is valid, the eviction lookup drives `evict_to_mem_o`=0 and `evict_dst_o`= the destination tile.
  - If the entry is invalid, it drives `evict_to_mem_o`=1 and `evict_dst_o`=0.
- R6: A write with selector 3 changes no table.
- R7: A walk is started by `walk_start_i` with source `walk_src_i`.
  - It follows valid pointers and stops at the first invalid one.
  - `walk_done_o` pulses for one cycle, hops+1 cycles after the start is sampled.
  - At the pulse, `walk_len_o` holds the number of hops, `walk_last_o` the last tile reached, and `walk_err_o`=0.
  - `walk_busy_o` is high from the start until the pulse.
- R8: If a valid pointer names a tile already visited in the current walk, the walk ends with `walk_err_o`=1. `walk_len_o` then holds the hops taken so far and is never above 8.
- R9: If a next-hop write hits a tile already visited during a walk, the walk is dropped. `walk_busy_o` falls and no done pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Table write strobe |
| wr_sel_i | input | 2 | Target table: 0 search, 1 sharer, 2 next-hop, 3 none |
| wr_tile_i | input | 3 | Entry index |
| wr_data_i | input | 8 | Write data |
| srch_core_i | input | 3 | Core for the search lookup |
| srch_set_o | output | 8 | Slices to search, own bit removed |
| shr_slice_i | input | 3 | Slice for the sharer lookup |
| shr_set_o | output | 8 | Sharer cores of the slice |
| evict_src_i | input | 3 | Tile evicting a block |
| evict_dst_o | output | 3 | Next tile for the victim block |
| evict_to_mem_o | output | 1 | Victim block goes to memory |
| walk_start_i | input | 1 | Start a chain walk |
| walk_src_i | input | 3 | Walk source tile |
| walk_busy_o | output | 1 | Walk in progress |
| walk_done_o | output | 1 | One-cycle end-of-walk pulse |
| walk_err_o | output | 1 | Last walk found a loop |
| walk_len_o | output | 4 | Hops in the last walk |
| walk_last_o | output | 3 | Last tile of the last walk |

## Verification
The checker tests the following on every cycle:
- each write becomes visible on its lookup port;
- the search result never contains the requesting core's own bit;
- a memory-bound eviction reports tile 0;
- the done pulse lasts one cycle and never overlaps busy;
- a loop report never exceeds the tile count;
- a write that hits the walker's current tile cancels the walk.

Only the bench scenarios can show that a complete multi-hop chain returns the right length and last tile, with the right latency. The same holds for the two loop shapes (a two-tile cycle and a tile that points to itself) and for a cancelled walk that stays silent.

// File: rtl/ec_route_pkg.sv
package ec_route_pkg;
  typedef enum logic [1:0] {
    SEL_SRCH = 2'd0,
    SEL_SHR  = 2'd1,
    SEL_NEXT = 2'd2,
    SEL_NONE = 2'd3
  } tbl_sel_e;
endpackage

// File: rtl/ec_vec_table.sv
module ec_vec_table #(
  parameter int N = 8,
  parameter int W = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [W-1:0]  rd_data_o
);
  logic [W-1:0] mem_q [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (wr_en_i && wr_idx_i == IW'(g)) mem_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/ec_next_table.sv
module ec_next_table #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic          wr_vld_i,
  input  logic [IW-1:0] wr_dst_i,
  input  logic [IW-1:0] ev_idx_i,
  output logic          ev_vld_o,
  output logic [IW-1:0] ev_dst_o,
  input  logic [IW-1:0] wk_idx_i,
  output logic          wk_vld_o,
  output logic [IW-1:0] wk_dst_o
);
  logic          vld_q [N];
  logic [IW-1:0] dst_q [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g] <= 1'b0;
        dst_q[g] <= '0;
      end else if (wr_en_i && wr_idx_i == IW'(g)) begin
        vld_q[g] <= wr_vld_i;
        dst_q[g] <= wr_dst_i;
      end
    end
  end

  assign ev_vld_o = vld_q[ev_idx_i];
  assign ev_dst_o = dst_q[ev_idx_i];
  assign wk_vld_o = vld_q[wk_idx_i];
  assign wk_dst_o = dst_q[wk_idx_i];
endmodule

// File: rtl/ec_chain_walker.sv
module ec_chain_walker #(
  parameter int N = 8,
  localparam int IW = $clog2(N),
  localparam int LW = $clog2(N + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [IW-1:0] src_i,
  input  logic          wr_next_i,
  input  logic [IW-1:0] wr_tile_i,
  output logic [IW-1:0] cur_o,
  input  logic          ptr_vld_i,
  input  logic [IW-1:0] ptr_dst_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [LW-1:0] len_o,
  output logic [IW-1:0] last_o
);
  logic [N-1:0]  seen_q;
  logic [IW-1:0] cur_q;
  logic [LW-1:0] hops_q;
  logic          abort, looped;

  // a rewritten pointer on the visited path invalidates the walk
  assign abort  = wr_next_i && seen_q[wr_tile_i];
  assign looped = seen_q[ptr_dst_i] || hops_q == LW'(N);
  assign cur_o  = cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= '0;
      cur_q  <= '0;
      hops_q <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
      len_o  <= '0;
      last_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        busy_o <= 1'b1;
        cur_q  <= src_i;
        seen_q <= N'(1) << src_i;
        hops_q <= '0;
      end else if (busy_o) begin
        if (abort) begin
          busy_o <= 1'b0;
          seen_q <= '0;
        end else if (!ptr_vld_i || looped) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
          err_o  <= ptr_vld_i;
          len_o  <= hops_q;
          last_o <= cur_q;
          seen_q <= '0;
        end else begin
          cur_q  <= ptr_dst_i;
          seen_q <= seen_q | (N'(1) << ptr_dst_i);
          hops_q <= hops_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ec_route_tables.sv
module ec_route_tables
  import ec_route_pkg::*;
#(
  parameter int N_TILES = 8,
  localparam int IW = $clog2(N_TILES),
  localparam int LW = $clog2(N_TILES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_sel_i,
  input  logic [IW-1:0]      wr_tile_i,
  input  logic [N_TILES-1:0] wr_data_i,
  input  logic [IW-1:0]      srch_core_i,
  output logic [N_TILES-1:0] srch_set_o,
  input  logic [IW-1:0]      shr_slice_i,
  output logic [N_TILES-1:0] shr_set_o,
  input  logic [IW-1:0]      evict_src_i,
  output logic [IW-1:0]      evict_dst_o,
  output logic               evict_to_mem_o,
  input  logic               walk_start_i,
  input  logic [IW-1:0]      walk_src_i,
  output logic               walk_busy_o,
  output logic               walk_done_o,
  output logic               walk_err_o,
  output logic [LW-1:0]      walk_len_o,
  output logic [IW-1:0]      walk_last_o
);
  logic               wr_srch, wr_shr, wr_next;
  logic [N_TILES-1:0] srch_raw;
  logic               ev_vld;
  logic [IW-1:0]      ev_dst;
  logic [IW-1:0]      walk_cur;
  logic               wk_vld;
  logic [IW-1:0]      wk_dst;

  assign wr_srch = wr_en_i && wr_sel_i == SEL_SRCH;
  assign wr_shr  = wr_en_i && wr_sel_i == SEL_SHR;
  assign wr_next = wr_en_i && wr_sel_i == SEL_NEXT;

  ec_vec_table #(.N(N_TILES), .W(N_TILES)) u_srch (
    .clk_i, .rst_ni, .wr_en_i(wr_srch), .wr_idx_i(wr_tile_i),
    .wr_data_i, .rd_idx_i(srch_core_i), .rd_data_o(srch_raw)
  );

  ec_vec_table #(.N(N_TILES), .W(N_TILES)) u_shr (
    .clk_i, .rst_ni, .wr_en_i(wr_shr), .wr_idx_i(wr_tile_i),
    .wr_data_i, .rd_idx_i(shr_slice_i), .rd_data_o(shr_set_o)
  );

  ec_next_table #(.N(N_TILES)) u_next (
    .clk_i, .rst_ni, .wr_en_i(wr_next), .wr_idx_i(wr_tile_i),
    .wr_vld_i(wr_data_i[IW]), .wr_dst_i(wr_data_i[IW-1:0]),
    .ev_idx_i(evict_src_i), .ev_vld_o(ev_vld), .ev_dst_o(ev_dst),
    .wk_idx_i(walk_cur), .wk_vld_o(wk_vld), .wk_dst_o(wk_dst)
  );

  ec_chain_walker #(.N(N_TILES)) u_walk (
    .clk_i, .rst_ni, .start_i(walk_start_i), .src_i(walk_src_i),
    .wr_next_i(wr_next), .wr_tile_i, .cur_o(walk_cur),
    .ptr_vld_i(wk_vld), .ptr_dst_i(wk_dst),
    .busy_o(walk_busy_o), .done_o(walk_done_o), .err_o(walk_err_o),
    .len_o(walk_len_o), .last_o(walk_last_o)
  );

  assign srch_set_o     = srch_raw & ~(N_TILES'(1) << srch_core_i);
  assign evict_to_mem_o = !ev_vld;
  assign evict_dst_o    = ev_vld ? ev_dst : '0;
endmodule

// File: rtl/ec_route_tables_chk.sv
module ec_route_tables_chk #(
  parameter int N_TILES = 8,
  localparam int IW = $clog2(N_TILES),
  localparam int LW = $clog2(N_TILES + 1)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [1:0]         wr_sel_i,
  input logic [IW-1:0]      wr_tile_i,
  input logic [N_TILES-1:0] wr_data_i,
  input logic [IW-1:0]      srch_core_i,
  input logic [N_TILES-1:0] srch_set_o,
  input logic [IW-1:0]      shr_slice_i,
  input logic [N_TILES-1:0] shr_set_o,
  input logic [IW-1:0]      evict_dst_o,
  input logic               evict_to_mem_o,
  input logic               walk_start_i,
  input logic               walk_busy_o,
  input logic               walk_done_o,
  input logic               walk_err_o,
  input logic [LW-1:0]      walk_len_o,
  input logic [IW-1:0]      walk_cur
);
  assert_search_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_sel_i == 2'd0 |=> srch_core_i != $past(wr_tile_i) ||
      srch_set_o == ($past(wr_data_i) & ~(N_TILES'(1) << srch_core_i)));

  assert_own_bit_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srch_set_o[srch_core_i] == 1'b0);

  assert_sharer_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_sel_i == 2'd1 |=> shr_slice_i != $past(wr_tile_i) ||
      shr_set_o == $past(wr_data_i));

  assert_mem_dst_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_to_mem_o |-> evict_dst_o == '0);

  assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    walk_done_o |=> !walk_done_o);

  assert_done_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    walk_done_o |-> !walk_busy_o);

  assert_loop_len_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    walk_done_o && walk_err_o |-> walk_len_o <= LW'(N_TILES));

  assert_abort_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    walk_busy_o && !walk_start_i && wr_en_i && wr_sel_i == 2'd2 &&
      wr_tile_i == walk_cur |=> !walk_busy_o && !walk_done_o);
endmodule

bind ec_route_tables ec_route_tables_chk #(.N_TILES(N_TILES)) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_tile_i, .wr_data_i,
  .srch_core_i, .srch_set_o, .shr_slice_i, .shr_set_o,
  .evict_dst_o, .evict_to_mem_o, .walk_start_i, .walk_busy_o,
  .walk_done_o, .walk_err_o, .walk_len_o, .walk_cur(walk_cur)
);

// File: tb/tb_ec_route_tables.sv
module tb_ec_route_tables;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  // {sel[1:0], tile[2:0], data[7:0], expected[7:0]}
  localparam logic [20:0] VEC [NV] = '{
    {2'd0, 3'd6, 8'b0000_1101, 8'b0000_1101},
    {2'd0, 3'd2, 8'b0000_1111, 8'b0000_1011},
    {2'd1, 3'd3, 8'b0100_0101, 8'b0100_0101},
    {2'd2, 3'd6, 8'h0B, 8'h03},
    {2'd2, 3'd3, 8'h0A, 8'h02},
    {2'd2, 3'd2, 8'h08, 8'h00},
    {2'd2, 3'd0, 8'h00, 8'h08},
    {2'd3, 3'd6, 8'hFF, 8'b0000_1101}
  };

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       wr_en_i = 1'b0, walk_start_i = 1'b0;
  logic [1:0] wr_sel_i = '0;
  logic [2:0] wr_tile_i = '0, srch_core_i = '0, shr_slice_i = '0, evict_src_i = '0, walk_src_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] srch_set_o, shr_set_o;
  logic [2:0] evict_dst_o, walk_last_o;
  logic       evict_to_mem_o, walk_busy_o, walk_done_o, walk_err_o;
  logic [3:0] walk_len_o;
  int n_chk = 0, n_fail = 0;

  ec_route_tables dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [2:0] t, logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = s; wr_tile_i = t; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  // returns cycles (negedges) until done; 0 if none within limit
  task automatic walk(logic [2:0] src, output int cyc);
    @(negedge clk_i);
    walk_src_i = src; walk_start_i = 1'b1;
    cyc = 0;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk_i);
      walk_start_i = 1'b0;
      if (walk_done_o) begin cyc = i; break; end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    srch_core_i = 3'd6; shr_slice_i = 3'd3; evict_src_i = 3'd6; #1;
    chk("R1 srch", 16'(srch_set_o), 16'h00);
    chk("R1 shr", 16'(shr_set_o), 16'h00);
    chk("R1 evict", {12'h0, evict_to_mem_o, evict_dst_o}, 16'h08);
    chk("R1 busy", 16'(walk_busy_o), 16'h0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] s; logic [2:0] t; logic [7:0] d, e;
      {s, t, d, e} = VEC[i];
      wr(s, t, d);
      srch_core_i = t; shr_slice_i = t; evict_src_i = t; #1;
      case (s)
        2'd0: chk(t == 3'd2 ? "R3 own bit masked" : "R2 search write", 16'(srch_set_o), 16'(e));
        2'd1: chk("R4 sharer write", 16'(shr_set_o), 16'(e));
        2'd2: chk("R5 evict lookup", {12'h0, evict_to_mem_o, evict_dst_o}, 16'(e));
        default: chk("R6 ignored write", 16'(srch_set_o), 16'(e));
      endcase
    end
    shr_slice_i = 3'd6; #1;
    chk("R6 sharer untouched", 16'(shr_set_o), 16'h00);

    // R7 chain 6->3->2->0->mem
    walk(3'd6, cyc);
    chk("R7 latency", 16'(cyc), 16'd5);
    chk("R7 len", 16'(walk_len_o), 16'd3);
    chk("R7 last", 16'(walk_last_o), 16'd0);
    chk("R7 err", 16'(walk_err_o), 16'd0);
    chk("R7 busy after", 16'(walk_busy_o), 16'd0);
    walk(3'd0, cyc);
    chk("R7 empty chain len", {cyc[7:0], 4'(walk_len_o), 4'(walk_last_o)}, {8'd2, 4'd0, 4'd0});

    // R8 two-tile loop 1->4->1
    wr(2'd2, 3'd1, 8'h0C);
    wr(2'd2, 3'd4, 8'h09);
    walk(3'd1, cyc);
    chk("R8 loop err", 16'(walk_err_o), 16'd1);
    chk("R8 loop len/last", {4'(walk_len_o), 4'(walk_last_o)}, {4'd1, 4'd4});
    // R8 self loop 5->5
    wr(2'd2, 3'd5, 8'h0D);
    walk(3'd5, cyc);
    chk("R8 self loop", {cyc[7:0], 3'b0, walk_err_o, 4'(walk_len_o)}, {8'd2, 4'd1, 4'd0});

    // R9 write on visited tile cancels the walk
    @(negedge clk_i);
    walk_src_i = 3'd6; walk_start_i = 1'b1;
    @(negedge clk_i);
    walk_start_i = 1'b0;
    wr_en_i = 1'b1; wr_sel_i = 2'd2; wr_tile_i = 3'd6; wr_data_i = 8'h0B;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    chk("R9 busy dropped", 16'(walk_busy_o), 16'd0);
    cyc = 0;
    for (int i = 0; i < 10; i++) begin
      if (walk_done_o) cyc++;
      @(negedge clk_i);
    end
    chk("R9 no done", 16'(cyc), 16'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule